// File: doc/BRIEF.md
# Signal Stream Packet Encoder

This block produces the byte-wide message stream that a host reads to learn the device inventory and the outcome of configuration register accesses. Every message is a packet: a 32-bit one-hot flag word, optionally followed by 32-bit data words. Words are split into bytes least-significant first. The packet is then byte-stuffed so that it contains no zero byte, and a single zero byte marks its end.

Two sources of packets exist. After reset, the block first announces the device table. It sends a table-start packet that holds the device count, then one device-instance packet per device, taken from a preloaded address and descriptor table. Only after that burst does it take acknowledgment requests from the register-access queue. Each request becomes exactly one packet: a read-OK acknowledgment carries the value that was read, and the other three kinds carry only the flag. The output uses a valid/ready handshake, and the host may stall it at any byte.

The packet builder has three states. BLD_TSTART moves to BLD_INST when its packet is taken. BLD_INST moves to the next device on each take, and from the last device to BLD_ACKS. BLD_ACKS is held until reset. The encoder has four states. EM_IDLE loads a packet and moves to EM_CODE. EM_CODE emits the code byte, then goes to EM_DATA if the block has bytes, to EM_CODE for an empty block, or to EM_DELIM at the end of the packet. EM_DATA emits the block bytes, then goes to EM_CODE or EM_DELIM. EM_DELIM emits the zero byte and returns to EM_IDLE.

Top module: `sigchan_cobs_enc`

## Requirements
- R1: Flag words are one-hot: write-OK 0x02, write-fail 0x04, read-OK 0x08, read-fail 0x10, table-start 0x20, device-instance 0x40.
- R2: A packet is encoded as a sequence of blocks. Each block is a code byte equal to 1 plus the number of non-zero bytes that follow it, up to the next zero byte of the packet or the end of the packet. That zero byte is consumed and is not sent. No 0x00 appears inside an encoded packet.
- R3: Every encoded packet ends with exactly one 0x00 byte. The output is idle for the cycle after that byte is accepted.
- R4: Each 32-bit word is placed into the packet bytes least-significant byte first, with words in order (flag first).
- R5: A block holds at most 254 data bytes. A full block has code 0xFF and implies no zero byte. If a full block ends the packet, the delimiter follows it directly.
- R6: When the last packet byte is zero, the encoded packet ends with an empty block, code 0x01, before the delimiter.
- R7: After reset, the first packet is table-start followed by the device count. Then one device-instance packet is sent per device, in index order. Each carries the device address and then its descriptor words, with descriptor word 0 first.
- R8: `ack_ready` stays low until the device-instance packet for the last device has been taken.
- R9: Each accepted acknowledgment produces exactly one packet. Read-OK (`ack_is_read`=1, `ack_ok`=1) sends 0x08 and then `ack_data`. Read-fail sends 0x10, write-OK sends 0x02 and write-fail sends 0x04, each with no data.
- R10: While `sig_valid` is high and `sig_ready` is low, `sig_valid` stays high and `sig_data` is unchanged in the next cycle.
- R11: While `rst_n` is low, `sig_valid` and `ack_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledgment request present |
| ack_ready | output | 1 | Acknowledgment request accepted this cycle |
| ack_is_read | input | 1 | 1 = read access, 0 = write access |
| ack_ok | input | 1 | 1 = access succeeded |
| ack_data | input | 32 | Value read by a successful read |
| tbl_addr | input | N_DEV*32 | Device addresses, device 0 in the low word |
| tbl_desc | input | N_DEV*DESC_WORDS*32 | Descriptors, device 0 word 0 in the low word |
| sig_data | output | 8 | Encoded stream byte |
| sig_valid | output | 1 | `sig_data` holds a byte |
| sig_ready | input | 1 | Host accepts the byte |

## Verification
The hardest case to reach from the ports is a run of 254 non-zero bytes. It only arises in long device-instance packets, and it matters most when the run ends exactly at the packet end. The bench therefore uses 64-word descriptors. For the first device it places zeros so that a full block falls mid-packet. For the second device it places a single zero in descriptor word 0 so that the remaining 254 bytes end the packet. An acknowledgment request is also held pending from reset, to show it is refused during the table burst.

// File: rtl/sigc_pkg.sv
`timescale 1ns/1ps
package sigc_pkg;
    localparam logic [31:0] FLG_WR_OK   = 32'h0000_0002;
    localparam logic [31:0] FLG_WR_FAIL = 32'h0000_0004;
    localparam logic [31:0] FLG_RD_OK   = 32'h0000_0008;
    localparam logic [31:0] FLG_RD_FAIL = 32'h0000_0010;
    localparam logic [31:0] FLG_TSTART  = 32'h0000_0020;
    localparam logic [31:0] FLG_DEVINST = 32'h0000_0040;

    // longest block payload; a full block carries no implied zero
    localparam int RUN_LIMIT = 254;

    typedef enum logic [1:0] {BLD_TSTART, BLD_INST, BLD_ACKS} bld_state_t;
    typedef enum logic [1:0] {EM_IDLE, EM_CODE, EM_DATA, EM_DELIM} em_state_t;
endpackage

// File: rtl/sigc_run_scan.sv
`timescale 1ns/1ps
module sigc_run_scan
    import sigc_pkg::*;
#(
    parameter int MAXB = 20,
    parameter int PW   = 9
) (
    input  logic [MAXB*8-1:0] mem_i,
    input  logic [PW-1:0]     pos_i,
    input  logic [PW-1:0]     len_i,
    output logic [7:0]        run_o
);
    localparam int SCANW = (MAXB < RUN_LIMIT) ? MAXB : RUN_LIMIT;

    // count non-zero bytes from pos_i, stopping at a zero, the end or the limit
    always_comb begin
        logic          stop;
        logic [PW-1:0] idx;
        logic [PW-1:0] sel;
        stop  = 1'b0;
        run_o = '0;
        for (int i = 0; i < SCANW; i++) begin
            idx = pos_i + PW'(i);
            sel = (idx < PW'(MAXB)) ? idx : '0;
            if (!stop) begin
                if ((idx < len_i) && (mem_i[int'(sel)*8 +: 8] != 8'h00))
                    run_o = run_o + 8'd1;
                else
                    stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sigc_pkt_build.sv
`timescale 1ns/1ps
module sigc_pkt_build
    import sigc_pkg::*;
#(
    parameter int N_DEV      = 4,
    parameter int DESC_WORDS = 3,
    localparam int MAXW = 2 + DESC_WORDS,
    localparam int NWW  = $clog2(MAXW + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ack_valid_i,
    input  logic                         ack_is_read_i,
    input  logic                         ack_ok_i,
    input  logic [31:0]                  ack_data_i,
    output logic                         ack_ready_o,
    input  logic [N_DEV*32-1:0]          tbl_addr_i,
    input  logic [N_DEV*DESC_WORDS*32-1:0] tbl_desc_i,
    output logic                         pkt_valid_o,
    output logic [MAXW*32-1:0]           pkt_words_o,
    output logic [NWW-1:0]               pkt_nwords_o,
    input  logic                         pkt_take_i
);
    localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int DW = DESC_WORDS * 32;

    bld_state_t    st_q, st_d;
    logic [IW-1:0] dev_q, dev_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BLD_TSTART;
            dev_q <= '0;
        end else begin
            st_q  <= st_d;
            dev_q <= dev_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        dev_d = dev_q;
        unique case (st_q)
            BLD_TSTART: if (pkt_take_i) begin
                st_d  = BLD_INST;
                dev_d = '0;
            end
            BLD_INST: if (pkt_take_i) begin
                if (dev_q == IW'(N_DEV - 1)) st_d = BLD_ACKS;
                else                         dev_d = dev_q + IW'(1);
            end
            BLD_ACKS: st_d = BLD_ACKS;
            default:  st_d = BLD_TSTART;
        endcase
    end

    // packet contents offered to the encoder
    always_comb begin
        pkt_valid_o  = 1'b0;
        pkt_words_o  = '0;
        pkt_nwords_o = NWW'(1);
        ack_ready_o  = 1'b0;
        unique case (st_q)
            BLD_TSTART: begin
                pkt_valid_o        = 1'b1;
                pkt_words_o[31:0]  = FLG_TSTART;
                pkt_words_o[63:32] = 32'(N_DEV);
                pkt_nwords_o       = NWW'(2);
            end
            BLD_INST: begin
                pkt_valid_o        = 1'b1;
                pkt_words_o[31:0]  = FLG_DEVINST;
                pkt_words_o[63:32] = tbl_addr_i[int'(dev_q)*32 +: 32];
                pkt_words_o[64 +: DW] = tbl_desc_i[int'(dev_q)*DW +: DW];
                pkt_nwords_o       = NWW'(MAXW);
            end
            BLD_ACKS: begin
                pkt_valid_o = ack_valid_i;
                ack_ready_o = pkt_take_i;
                if (ack_is_read_i) begin
                    pkt_words_o[31:0] = ack_ok_i ? FLG_RD_OK : FLG_RD_FAIL;
                    if (ack_ok_i) begin
                        pkt_words_o[63:32] = ack_data_i;
                        pkt_nwords_o       = NWW'(2);
                    end
                end else begin
                    pkt_words_o[31:0] = ack_ok_i ? FLG_WR_OK : FLG_WR_FAIL;
                end
            end
            default: pkt_valid_o = 1'b0;
        endcase
    end

    // R1
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> ($countones(pkt_words_o[31:0]) == 1));
endmodule

// File: rtl/sigc_cobs_emit.sv
`timescale 1ns/1ps
module sigc_cobs_emit
    import sigc_pkg::*;
#(
    parameter int MAXW = 5,
    localparam int MAXB = 4 * MAXW,
    localparam int PW   = $clog2(MAXB + RUN_LIMIT + 2),
    localparam int NWW  = $clog2(MAXW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid_i,
    input  logic [MAXB*8-1:0] pkt_bytes_i,
    input  logic [NWW-1:0]    pkt_nwords_i,
    output logic              pkt_take_o,
    output logic [7:0]        out_data_o,
    output logic              out_valid_o,
    input  logic              out_ready_i
);
    em_state_t         st_q, st_d;
    logic [MAXB*8-1:0] mem_q;
    logic [PW-1:0]     len_q;
    logic [PW-1:0]     pos_q, pos_d;
    logic [PW-1:0]     ptr_q, ptr_d;
    logic [7:0]        runq_q, runq_d;
    logic [7:0]        run_c, blk_run;
    logic [PW-1:0]     blk_end, nxt_pos;
    logic              blk_done, fire;

    sigc_run_scan #(.MAXB(MAXB), .PW(PW)) u_scan (
        .mem_i (mem_q),
        .pos_i (pos_q),
        .len_i (len_q),
        .run_o (run_c)
    );

    // block bookkeeping: end of current block and start of the next one
    always_comb begin
        blk_run  = (st_q == EM_CODE) ? run_c : runq_q;
        blk_end  = pos_q + PW'(blk_run);
        blk_done = (blk_end == len_q);
        nxt_pos  = (blk_run == 8'(RUN_LIMIT)) ? blk_end : blk_end + PW'(1);
    end

    // outputs
    always_comb begin
        out_valid_o = (st_q != EM_IDLE);
        pkt_take_o  = (st_q == EM_IDLE) && pkt_valid_i;
        unique case (st_q)
            EM_IDLE:  out_data_o = 8'h00;
            EM_CODE:  out_data_o = run_c + 8'd1;
            EM_DATA:  out_data_o = mem_q[int'(ptr_q)*8 +: 8];
            EM_DELIM: out_data_o = 8'h00;
            default:  out_data_o = 8'h00;
        endcase
    end

    assign fire = out_valid_o && out_ready_i;

    // transitions
    always_comb begin
        st_d   = st_q;
        pos_d  = pos_q;
        ptr_d  = ptr_q;
        runq_d = runq_q;
        unique case (st_q)
            EM_IDLE: if (pkt_valid_i) begin
                st_d  = EM_CODE;
                pos_d = '0;
            end
            EM_CODE: if (fire) begin
                runq_d = run_c;
                ptr_d  = pos_q;
                if (run_c != 8'd0)  st_d = EM_DATA;
                else if (blk_done)  st_d = EM_DELIM;
                else                pos_d = nxt_pos;
            end
            EM_DATA: if (fire) begin
                if (ptr_q == blk_end - PW'(1)) begin
                    if (blk_done) st_d = EM_DELIM;
                    else begin
                        st_d  = EM_CODE;
                        pos_d = nxt_pos;
                    end
                end else begin
                    ptr_d = ptr_q + PW'(1);
                end
            end
            EM_DELIM: if (fire) st_d = EM_IDLE;
            default:  st_d = EM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EM_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            ptr_q  <= '0;
            runq_q <= '0;
            mem_q  <= '0;
            len_q  <= '0;
        end else begin
            pos_q  <= pos_d;
            ptr_q  <= ptr_d;
            runq_q <= runq_d;
            if (pkt_take_o) begin
                mem_q <= pkt_bytes_i;
                len_q <= PW'(pkt_nwords_i) << 2;
            end
        end
    end

    // R2
    no_zero_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && st_q != EM_DELIM) |-> (out_data_o != 8'h00));
    // R3
    gap_after_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_data_o == 8'h00) |=> !out_valid_o);
    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/sigchan_cobs_enc.sv
`timescale 1ns/1ps
module sigchan_cobs_enc
    import sigc_pkg::*;
#(
    parameter int N_DEV      = 4,
    parameter int DESC_WORDS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ack_valid,
    output logic                           ack_ready,
    input  logic                           ack_is_read,
    input  logic                           ack_ok,
    input  logic [31:0]                    ack_data,
    input  logic [N_DEV*32-1:0]            tbl_addr,
    input  logic [N_DEV*DESC_WORDS*32-1:0] tbl_desc,
    output logic [7:0]                     sig_data,
    output logic                           sig_valid,
    input  logic                           sig_ready
);
    localparam int MAXW = 2 + DESC_WORDS;
    localparam int NWW  = $clog2(MAXW + 1);

    logic                 pkt_valid, pkt_take;
    logic [MAXW*32-1:0]   pkt_words;
    logic [NWW-1:0]       pkt_nwords;

    sigc_pkt_build #(.N_DEV(N_DEV), .DESC_WORDS(DESC_WORDS)) u_build (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack_valid_i   (ack_valid),
        .ack_is_read_i (ack_is_read),
        .ack_ok_i      (ack_ok),
        .ack_data_i    (ack_data),
        .ack_ready_o   (ack_ready),
        .tbl_addr_i    (tbl_addr),
        .tbl_desc_i    (tbl_desc),
        .pkt_valid_o   (pkt_valid),
        .pkt_words_o   (pkt_words),
        .pkt_nwords_o  (pkt_nwords),
        .pkt_take_i    (pkt_take)
    );

    sigc_cobs_emit #(.MAXW(MAXW)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_valid_i  (pkt_valid),
        .pkt_bytes_i  (pkt_words),
        .pkt_nwords_i (pkt_nwords),
        .pkt_take_o   (pkt_take),
        .out_data_o   (sig_data),
        .out_valid_o  (sig_valid),
        .out_ready_i  (sig_ready)
    );
endmodule

// File: tb/sigchan_cobs_enc_bench.sv
`timescale 1ns/1ps
module sigchan_cobs_enc_bench;
    localparam int ND   = 2;
    localparam int DWN  = 64;
    localparam int MAXB = 4 * (2 + DWN);
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_valid = 1'b0, ack_is_read = 1'b0, ack_ok = 1'b0, ack_ready;
    logic [31:0] ack_data = '0;
    logic [ND*32-1:0] tbl_addr;
    logic [ND*DWN*32-1:0] tbl_desc;
    logic [7:0] sig_data;
    logic sig_valid;
    logic sig_ready = 1'b1;

    always #2.5 clk = ~clk;

    sigchan_cobs_enc #(.N_DEV(ND), .DESC_WORDS(DWN)) u_sigchan_cobs_enc (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
        .ack_is_read(ack_is_read), .ack_ok(ack_ok), .ack_data(ack_data),
        .tbl_addr(tbl_addr), .tbl_desc(tbl_desc),
        .sig_data(sig_data), .sig_valid(sig_valid), .sig_ready(sig_ready)
    );

    // stimulus and expected outcome: {is_read, ok, data}
    localparam logic [33:0] VEC [8] = '{
        34'h3_0000_0000, 34'h3_1200_3400, 34'h3_FFFF_FFFF, 34'h2_DEAD_BEEF,
        34'h1_0000_0000, 34'h0_0000_0000, 34'h3_A500_0000, 34'h3_0000_00C3
    };

    int checks = 0, fails = 0, wd = 0, cyc = 0;
    bit stall_en = 1'b0, mon_on = 1'b0, ack_early = 1'b0;
    logic [7:0] raw [0:299];
    logic [7:0] enc [0:319];
    logic [7:0] got [0:319];
    int rlen, elen, glen;

    always @(posedge clk) wd <= wd + 1;

    function automatic logic [31:0] desc_word(int d, int j);
        if (d == 1 && j == 0) return 32'h3344_0022;
        return {8'(j + 1), 8'hA5, 8'(j + 1), 8'h5A};
    endfunction

    function automatic logic [31:0] addr_of(int d);
        return (d == 0) ? 32'h0000_0100 : 32'h00C0_FFEE;
    endfunction

    task automatic put_word(int off, logic [31:0] w);
        for (int k = 0; k < 4; k++) raw[off + k] = w[8*k +: 8];
    endtask

    task automatic build_ack(bit rd, bit ok, logic [31:0] d);
        put_word(0, rd ? (ok ? 32'h08 : 32'h10) : (ok ? 32'h02 : 32'h04));
        rlen = 4;
        if (rd && ok) begin put_word(4, d); rlen = 8; end
    endtask

    task automatic build_tstart();
        put_word(0, 32'h20); put_word(4, 32'(ND)); rlen = 8;
    endtask

    task automatic build_inst(int d);
        put_word(0, 32'h40); put_word(4, addr_of(d));
        for (int j = 0; j < DWN; j++) put_word(8 + 4*j, desc_word(d, j));
        rlen = MAXB;
    endtask

    // reference byte stuffing written from the requirements
    task automatic cobs_ref();
        int ci, code;
        bit ff_end;
        ci = 0; elen = 1; code = 1; ff_end = 1'b0;
        for (int i = 0; i < rlen; i++) begin
            if (raw[i] == 8'h00) begin
                enc[ci] = 8'(code); ci = elen; elen++; code = 1;
            end else begin
                enc[elen] = raw[i]; elen++; code++;
                if (code == 255) begin
                    enc[ci] = 8'hFF;
                    if (i != rlen - 1) begin ci = elen; elen++; code = 1; end
                    else ff_end = 1'b1;
                end
            end
        end
        if (!ff_end) enc[ci] = 8'(code);
        enc[elen] = 8'h00; elen++;
    endtask

    task automatic get_pkt();
        bit done, prev_stall;
        logic [7:0] pd;
        glen = 0; done = 1'b0; prev_stall = 1'b0; pd = '0;
        while (!done && wd < WD_LIMIT) begin
            @(negedge clk);
            if (prev_stall) begin
                checks++;
                if (!(sig_valid && sig_data == pd)) begin
                    fails++;
                    $display("FAIL R10 stall hold: valid=%0b data=%02h expected valid=1 data=%02h",
                             sig_valid, sig_data, pd);
                end
            end
            sig_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
            cyc++;
            if (mon_on && ack_ready) ack_early = 1'b1;
            if (sig_valid && sig_ready && glen < 320) begin
                got[glen] = sig_data; glen++;
                if (sig_data == 8'h00) done = 1'b1;
            end
            prev_stall = sig_valid && !sig_ready;
            pd = sig_data;
        end
    endtask

    task automatic check_pkt(string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < elen && i < glen; i++)
            if (bad < 0 && got[i] != enc[i]) bad = i;
        if (bad < 0 && glen != elen) bad = (glen < elen) ? glen : elen;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: len=%0d byte[%0d]=%02h expected len=%0d byte=%02h",
                     tag, glen, bad, (bad < glen) ? got[bad] : 8'hXX, elen,
                     (bad < elen) ? enc[bad] : 8'hXX);
        end
    endtask

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_ack(bit rd, bit ok, logic [31:0] d);
        ack_is_read = rd; ack_ok = ok; ack_data = d; ack_valid = 1'b1;
        do @(negedge clk); while (!ack_ready && wd < WD_LIMIT);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        wait (wd >= WD_LIMIT);
        fails++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) begin
            tbl_addr[d*32 +: 32] = addr_of(d);
            for (int j = 0; j < DWN; j++) tbl_desc[(d*DWN + j)*32 +: 32] = desc_word(d, j);
        end
        // write-OK request pending from reset onward
        ack_valid = 1'b1; ack_is_read = 1'b0; ack_ok = 1'b1;
        repeat (4) @(negedge clk);
        check_val("R11 sig_valid in reset", int'(sig_valid), 0);
        check_val("R11 ack_ready in reset", int'(ack_ready), 0);
        rst_n = 1'b1;

        // R7 table burst, R8 acks held off
        mon_on = 1'b1;
        build_tstart(); cobs_ref(); get_pkt();
        check_pkt("R7 table start (R2 R4)");
        build_inst(0); cobs_ref(); get_pkt();
        check_pkt("R7 device 0 instance");
        check_val("R5 full block code mid packet", int'(got[8]), 'hFF);
        build_inst(1); cobs_ref(); get_pkt();
        check_pkt("R7 device 1 instance");
        check_val("R5 length when full block ends packet", glen, 266);
        check_val("R5 last byte before delimiter", int'(got[glen-2]), 'h40);
        mon_on = 1'b0;
        check_val("R8 ack_ready during table burst", int'(ack_early), 0);

        build_ack(1'b0, 1'b1, 32'h0); cobs_ref();
        fork
            send_ack(1'b0, 1'b1, 32'h0);
            get_pkt();
        join
        check_pkt("R9 first ack after burst");

        for (int i = 0; i < 8; i++) begin
            stall_en = i[0];
            build_ack(VEC[i][33], VEC[i][32], VEC[i][31:0]); cobs_ref();
            fork
                send_ack(VEC[i][33], VEC[i][32], VEC[i][31:0]);
                get_pkt();
            join
            check_pkt("R9 R4 R2 ack vector");
            if (i == 0) begin
                check_val("R6 final empty block code", int'(got[glen-2]), 1);
                check_val("R3 delimiter", int'(got[glen-1]), 0);
            end
        end

        // reset in the middle of a packet restarts the table burst
        stall_en = 1'b1;
        ack_is_read = 1'b1; ack_ok = 1'b1; ack_data = 32'h0102_0304; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_val("R11 sig_valid in second reset", int'(sig_valid), 0);
        check_val("R11 ack_ready in second reset", int'(ack_ready), 0);
        rst_n = 1'b1;
        build_tstart(); cobs_ref(); get_pkt();
        check_pkt("R7 table start after reset");
        build_inst(0); cobs_ref(); get_pkt();
        check_pkt("R7 device 0 after reset");
        build_inst(1); cobs_ref(); get_pkt();
        check_pkt("R7 device 1 after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule